// File: doc/BRIEF.md
# Switching-Cycle Phase Synchronizer

This block produces the start-of-cycle timing for a switching regulator controller. It runs on a fast system clock and divides it down to a nominal 1 MHz switching cycle. A mode strap decides which way a shared synchronization pin works.

When the strap is high, the block is the timing source. A free-running divider marks each cycle boundary, and the block drives a square wave onto the sync pin with its output enable asserted. When the strap is low, the pin is an input. The block measures the time between rising edges on the incoming sync signal. It then starts its own cycle half a measured period after each rising edge, which places it 180 degrees away from the sender.

If the incoming period leaves the ±20% acceptance window, or if the edges stop arriving, the block raises a fault flag. It then runs from its own divider until a valid period is measured again. A one-clock strobe marks every cycle boundary in both modes.

Top module: `sync_phase_unit`

## Requirements
- R1: While `rstN` is low, `cycleStart`, `syncOut`, `syncOe` and `syncFault` are all 0.
- R2: With `masterMode` high, `cycleStart` is a one-clock pulse that repeats exactly every `NOM_DIV` clocks (default 50, which gives 1 MHz from 50 MHz).
- R3: With `masterMode` high, `syncOe` is 1 and `syncOut` is 1 for exactly `NOM_DIV/2` cycles starting with each `cycleStart` cycle, and 0 for the rest of the period.
- R4: With `masterMode` low, `syncOe` and `syncOut` stay 0, so the pin is never driven.
- R5: In slave mode, the period P is the number of clocks between consecutive rising edges of `syncIn`. P is accepted when `NOM_DIV*4/5 <= P <= NOM_DIV*6/5` (40 to 60 by default). Any other value is rejected.
- R6: In slave mode, an accepted period locks the block. Take a `syncIn` rise that lands between clock edges k and k+1. The strobe then appears in the cycle after edge k+3+floor(P/2), where 3 is the synchronizer plus edge-detect latency. While locked, no other strobes occur.
- R7: A rejected period sets `syncFault` in the cycle after edge k+3 of the rise that closed it, drops lock and cancels any pending start.
- R8: If no rising edge is detected for `NOM_DIV*3/2` (75) clocks after the last one, `syncFault` sets in the cycle after edge k+78 of that last rise.
- R9: While unlocked in slave mode, the internal divider produces the strobes. Each fault event restarts it, so the next strobe comes exactly `NOM_DIV` cycles after the cycle in which `syncFault` (re)asserts.
- R10: If a rejected edge is detected in the same cycle that a scheduled start is due, the start is suppressed and the fault wins.
- R11: After a timeout, the first rising edge only serves as a reference and leaves `syncFault` set. The next accepted period clears `syncFault` at edge k+3 and relocks.
- R12: In master mode, `syncIn` has no effect on `cycleStart` or `syncOut`, and `syncFault` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (NOM_DIV times the switching frequency) |
| rstN | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | Strap: 1 drives the sync pin, 0 receives on it |
| syncIn | input | 1 | Incoming sync signal, asynchronous |
| syncOut | output | 1 | Sync square wave driven in master mode |
| syncOe | output | 1 | Output enable for the sync pin |
| cycleStart | output | 1 | One-clock strobe at each switching-cycle boundary |
| syncFault | output | 1 | Incoming sync missing or outside the window |

## Verification
The collision that matters is between the phase scheduler and the loss-of-lock path. A start that was scheduled from one incoming edge can fall due in the same cycle as the next edge, and that next edge can close a rejected period. The bench provokes this by locking on 50-clock periods and then sending an edge only 25 clocks later, so the due start and the rejected measurement land together. It then confirms three things: no strobe appears at the due slot, the fault rises that cycle, and the restarted divider strobes exactly one nominal period later. A sweep of incoming periods from 30 to 70 clocks covers both window edges, including the accept/reject decision at 39/40 and 60/61.

// File: rtl/sync_phase_pkg.sv
`timescale 1ns/1ps
package sync_phase_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic divClear;     // restart the internal divider from zero
    logic phaseLoad;    // load half the measured period into the phase counter
    logic phaseCancel;  // drop a pending scheduled start
    logic drivePin;     // produce the outgoing square wave
  } ctl_strobe_t;

  // Events from the datapath to the control
  typedef struct packed {
    logic edgeSeen;     // synchronized rising edge of the incoming sync
    logic timeoutHit;   // no edge for the timeout span
    logic phaseDue;     // scheduled start falls in this cycle
    logic divWrap;      // divider at its last count
  } dp_status_t;

endpackage

// File: rtl/sync_phase_datapath.sv
`timescale 1ns/1ps
module sync_phase_datapath
  import sync_phase_pkg::*;
#(
  parameter int NOM_DIV     = 50,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT     = 75,
  parameter int MAX_HALF    = 30,
  parameter int CNT_W       = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  ctl_strobe_t      ctl,
  output dp_status_t       stat,
  output logic [CNT_W-1:0] periodMeas,
  output logic             syncOut
);

  localparam int DIV_W    = $clog2(NOM_DIV);
  localparam int HALF_NOM = NOM_DIV / 2;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(NOM_DIV - 1);
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(HALF_NOM);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(TIMEOUT);
  localparam logic [CNT_W-1:0] CNT_TRIP = CNT_W'(TIMEOUT - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  // Input synchronizer with one extra stage for edge detection
  logic [SYNC_STAGES:0] syncPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[SYNC_STAGES-1:0], syncIn};
  end

  logic edgeNow;
  assign edgeNow = syncPipe[SYNC_STAGES-1] & ~syncPipe[SYNC_STAGES];

  // Internal divider and outgoing square wave
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divNext;
  logic             wrapNow;

  assign wrapNow = (divCnt == DIV_LAST);

  always_comb begin
    if (ctl.divClear)  divNext = '0;
    else if (wrapNow)  divNext = '0;
    else               divNext = divCnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      syncOut <= 1'b0;
    end else begin
      divCnt  <= divNext;
      syncOut <= ctl.drivePin && (divNext < DIV_HALF);
    end
  end

  // Incoming period measurement with saturation at the timeout span
  logic [CNT_W-1:0] periodCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  periodCnt <= '0;
    else if (edgeNow)           periodCnt <= '0;
    else if (periodCnt != CNT_TOP) periodCnt <= periodCnt + CNT_ONE;
  end

  assign periodMeas = periodCnt + CNT_ONE;

  // Half-period delay from an accepted edge to the local start
  logic [CNT_W-1:0] phaseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phaseCnt <= '0;
    else if (ctl.phaseLoad)   phaseCnt <= periodMeas >> 1;
    else if (ctl.phaseCancel) phaseCnt <= '0;
    else if (phaseCnt != '0)  phaseCnt <= phaseCnt - CNT_ONE;
  end

  always_comb begin
    stat.edgeSeen   = edgeNow;
    stat.timeoutHit = !edgeNow && (periodCnt == CNT_TRIP);
    stat.phaseDue   = (phaseCnt == CNT_ONE);
    stat.divWrap    = wrapNow;
  end

  // R4: the square wave stays low whenever the control does not ask for it
  p_pin_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.drivePin |=> !syncOut);

  // R6: only accepted periods reach the phase counter
  p_phase_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    phaseCnt <= CNT_W'(MAX_HALF));

  // R8: the timeout event fires once per silent stretch
  p_timeout_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    stat.timeoutHit |=> !stat.timeoutHit);

endmodule

// File: rtl/sync_phase_control.sv
`timescale 1ns/1ps
module sync_phase_control
  import sync_phase_pkg::*;
#(
  parameter int MIN_P = 40,
  parameter int MAX_P = 60,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterMode,
  input  dp_status_t       stat,
  input  logic [CNT_W-1:0] periodMeas,
  output ctl_strobe_t      ctl,
  output logic             cycleStart,
  output logic             syncOe,
  output logic             syncFault
);

  localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(MIN_P);
  localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(MAX_P);

  logic locked;
  logic haveRef;

  logic inWindow;
  logic goodEdge;
  logic badEdge;
  logic toEvt;
  logic lossEvt;
  logic clearDiv;
  logic startNext;

  always_comb begin
    inWindow = (periodMeas >= LO_LIM) && (periodMeas <= HI_LIM);
    goodEdge = !masterMode && stat.edgeSeen && haveRef && inWindow;
    badEdge  = !masterMode && stat.edgeSeen && haveRef && !inWindow;
    toEvt    = !masterMode && stat.timeoutHit;
    lossEvt  = badEdge || toEvt;
    clearDiv = !masterMode && (locked || goodEdge || lossEvt);

    ctl.drivePin    = masterMode;
    ctl.divClear    = clearDiv;
    ctl.phaseLoad   = goodEdge;
    ctl.phaseCancel = lossEvt || masterMode;

    if (masterMode)  startNext = stat.divWrap;
    else if (locked) startNext = stat.phaseDue && !lossEvt;
    else             startNext = stat.divWrap && !clearDiv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked     <= 1'b0;
      haveRef    <= 1'b0;
      syncFault  <= 1'b0;
      cycleStart <= 1'b0;
      syncOe     <= 1'b0;
    end else begin
      cycleStart <= startNext;
      syncOe     <= masterMode;
      if (masterMode) begin
        locked    <= 1'b0;
        haveRef   <= 1'b0;
        syncFault <= 1'b0;
      end else begin
        if (stat.edgeSeen) haveRef <= 1'b1;
        else if (toEvt)    haveRef <= 1'b0;

        if (goodEdge)     locked <= 1'b1;
        else if (lossEvt) locked <= 1'b0;

        if (lossEvt)       syncFault <= 1'b1;
        else if (goodEdge) syncFault <= 1'b0;
      end
    end
  end

  // R2: a strobe never lasts longer than one clock
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |=> !cycleStart);

  // R4: the pin enable stays off in slave mode
  p_oe_slave_r4: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |=> !syncOe);

  // R12: no fault is reported while driving
  p_no_fault_master_r12: assert property (@(posedge clk) disable iff (!rstN)
    masterMode |=> !syncFault);

  // R11: the fault only clears together with a fresh lock
  p_unfault_locked_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(syncFault) && !masterMode) |-> locked);

  // R10: a rejected edge is never followed by a strobe
  p_cancel_r10: assert property (@(posedge clk) disable iff (!rstN)
    badEdge |=> !cycleStart);

endmodule

// File: rtl/sync_phase_unit.sv
`timescale 1ns/1ps
module sync_phase_unit
  import sync_phase_pkg::*;
#(
  parameter int NOM_DIV     = 50,
  parameter int WIN_PCT     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic masterMode,
  input  logic syncIn,
  output logic syncOut,
  output logic syncOe,
  output logic cycleStart,
  output logic syncFault
);

  localparam int MIN_P    = NOM_DIV * (100 - WIN_PCT) / 100;
  localparam int MAX_P    = NOM_DIV * (100 + WIN_PCT) / 100;
  localparam int TIMEOUT  = NOM_DIV * 3 / 2;
  localparam int MAX_HALF = MAX_P / 2;
  localparam int CNT_W    = $clog2(TIMEOUT + 2);

  ctl_strobe_t      ctl;
  dp_status_t       stat;
  logic [CNT_W-1:0] periodMeas;

  sync_phase_datapath #(
    .NOM_DIV    (NOM_DIV),
    .SYNC_STAGES(SYNC_STAGES),
    .TIMEOUT    (TIMEOUT),
    .MAX_HALF   (MAX_HALF),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .syncIn    (syncIn),
    .ctl       (ctl),
    .stat      (stat),
    .periodMeas(periodMeas),
    .syncOut   (syncOut)
  );

  sync_phase_control #(
    .MIN_P(MIN_P),
    .MAX_P(MAX_P),
    .CNT_W(CNT_W)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .masterMode(masterMode),
    .stat      (stat),
    .periodMeas(periodMeas),
    .ctl       (ctl),
    .cycleStart(cycleStart),
    .syncOe    (syncOe),
    .syncFault (syncFault)
  );

endmodule

// File: tb/sync_phase_unit_test.sv
`timescale 1ns/1ps
module sync_phase_unit_test;

  localparam int NOM  = 50;
  localparam int HALF = NOM / 2;
  localparam int MINP = NOM * 4 / 5;
  localparam int MAXP = NOM * 6 / 5;
  localparam int TOUT = NOM * 3 / 2;
  localparam int LAT  = 3;
  localparam int HI   = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b0;
  logic syncIn = 1'b0;
  logic syncOut, syncOe, cycleStart, syncFault;

  always #10 clk = ~clk;

  sync_phase_unit uut (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .syncIn(syncIn),
    .syncOut(syncOut), .syncOe(syncOe), .cycleStart(cycleStart), .syncFault(syncFault)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;
  bit monOn = 0;
  int strobeLog [0:1023];
  int nLog = 0;
  int faultRise = -1;
  bit prevFault = 0;
  int lastStrobe = -1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  function automatic bit hasAt(input int t);
    for (int i = 0; i < nLog; i++) if (strobeLog[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int countIn(input int lo, input int hi);
    int n = 0;
    for (int i = 0; i < nLog; i++) if (strobeLog[i] >= lo && strobeLog[i] <= hi) n++;
    return n;
  endfunction

  // Monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (monOn) begin
      if (cycleStart && nLog < 1024) begin
        strobeLog[nLog] = cyc;
        nLog++;
      end
      if (syncFault && !prevFault && faultRise < 0) faultRise = cyc;
      prevFault = syncFault;
      if (!masterMode) begin
        check(!syncOe && !syncOut, "R4 pin quiet in slave", {syncOe, syncOut}, 0);
      end else begin
        if (cycleStart) lastStrobe = cyc;
        check(syncOe, "R3 output enable in master", syncOe, 1);
        check(!syncFault, "R12 no fault in master", syncFault, 0);
        if (lastStrobe >= 0)
          check(syncOut == ((cyc - lastStrobe) < HALF), "R3 square wave phase",
                syncOut, int'((cyc - lastStrobe) < HALF));
      end
    end
  end

  task automatic waitCyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pulse(input int at);
    waitCyc(at);
    syncIn = 1'b1;
    waitCyc(at + HI);
    syncIn = 1'b0;
  endtask

  task automatic doReset(input bit mm);
    monOn = 0;
    rstN = 1'b0;
    syncIn = 1'b0;
    masterMode = mm;
    repeat (3) @(negedge clk);
    check({cycleStart, syncOut, syncOe, syncFault} == 4'b0, "R1 outputs low in reset",
          {cycleStart, syncOut, syncOe, syncFault}, 0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    nLog = 0;
    faultRise = -1;
    prevFault = 0;
    lastStrobe = -1;
    monOn = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int k1, k3, j1, j2, t0;

    // Master mode with noise on syncIn (R2, R3, R12)
    doReset(1'b1);
    t0 = cyc;
    while (cyc < t0 + 8 * NOM) begin
      syncIn = ((cyc * 7) % 13) < 5;
      @(negedge clk);
    end
    syncIn = 1'b0;
    check(nLog >= 6, "R2 master strobes present", nLog, 6);
    for (int i = 1; i < nLog; i++)
      check(strobeLog[i] - strobeLog[i-1] == NOM, "R2 master period / R12 syncIn ignored",
            strobeLog[i] - strobeLog[i-1], NOM);

    // Sweep of incoming periods across both window edges (R5, R6, R7, R9)
    for (int p = 30; p <= 70; p++) begin
      int k [4];
      doReset(1'b0);
      k[0] = cyc + 10;
      for (int i = 1; i < 4; i++) k[i] = k[i-1] + p;
      for (int i = 0; i < 4; i++) pulse(k[i]);
      waitCyc(k[3] + NOM + 10);
      if (p >= MINP && p <= MAXP) begin
        for (int i = 1; i < 4; i++)
          check(hasAt(k[i] + LAT + p / 2), "R6 locked start half period after edge",
                int'(hasAt(k[i] + LAT + p / 2)), 1);
        check(countIn(k[1] + LAT, k[3] + LAT + p / 2) == 3, "R6 no extra strobes while locked",
              countIn(k[1] + LAT, k[3] + LAT + p / 2), 3);
        check(faultRise < 0, "R5 accepted period raises no fault", faultRise, -1);
      end else begin
        check(faultRise == k[1] + LAT, "R5 R7 rejected period sets fault", faultRise, k[1] + LAT);
        check(countIn(k[3] + LAT, k[3] + LAT + NOM - 1) == 0, "R9 divider restarted at fault",
              countIn(k[3] + LAT, k[3] + LAT + NOM - 1), 0);
        check(hasAt(k[3] + LAT + NOM), "R9 fallback strobe one period after fault",
              int'(hasAt(k[3] + LAT + NOM)), 1);
      end
    end

    // Timeout, fallback and recovery (R8, R9, R11)
    doReset(1'b0);
    k1 = cyc + 10;
    pulse(k1);
    pulse(k1 + NOM);
    k3 = k1 + 2 * NOM;
    pulse(k3);
    waitCyc(k3 + LAT + TOUT + NOM + 5);
    check(hasAt(k3 + LAT + HALF), "R6 start from last edge", int'(hasAt(k3 + LAT + HALF)), 1);
    check(faultRise == k3 + LAT + TOUT, "R8 timeout fault", faultRise, k3 + LAT + TOUT);
    check(countIn(k3 + LAT + HALF + 1, k3 + LAT + TOUT + NOM - 1) == 0, "R9 quiet until fallback",
          countIn(k3 + LAT + HALF + 1, k3 + LAT + TOUT + NOM - 1), 0);
    check(hasAt(k3 + LAT + TOUT + NOM), "R9 fallback strobe after timeout",
          int'(hasAt(k3 + LAT + TOUT + NOM)), 1);
    j1 = cyc + 20;
    j2 = j1 + NOM;
    pulse(j1);
    waitCyc(j1 + LAT + 5);
    check(syncFault, "R11 first edge after timeout keeps fault", syncFault, 1);
    waitCyc(j2);
    syncIn = 1'b1;
    waitCyc(j2 + LAT - 1);
    check(syncFault, "R11 fault held until measurement", syncFault, 1);
    waitCyc(j2 + LAT);
    check(!syncFault, "R11 accepted period clears fault", syncFault, 0);
    waitCyc(j2 + HI);
    syncIn = 1'b0;
    waitCyc(j2 + LAT + HALF + 2);
    check(hasAt(j2 + LAT + HALF), "R11 relocked start", int'(hasAt(j2 + LAT + HALF)), 1);

    // Rejected edge exactly when a scheduled start is due (R10)
    doReset(1'b0);
    k1 = cyc + 10;
    pulse(k1);
    pulse(k1 + NOM);
    k3 = k1 + 2 * NOM;
    pulse(k3);
    pulse(k3 + HALF);
    waitCyc(k3 + HALF + LAT + NOM + 5);
    check(!hasAt(k3 + LAT + HALF), "R10 due start suppressed", int'(hasAt(k3 + LAT + HALF)), 0);
    check(countIn(k3 + LAT + 1, k3 + HALF + LAT + NOM - 1) == 0, "R10 no strobe around collision",
          countIn(k3 + LAT + 1, k3 + HALF + LAT + NOM - 1), 0);
    check(faultRise == k3 + HALF + LAT, "R10 R7 fault at collision", faultRise, k3 + HALF + LAT);
    check(hasAt(k3 + HALF + LAT + NOM), "R9 fallback after collision",
          int'(hasAt(k3 + HALF + LAT + NOM)), 1);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule